// File: doc/BRIEF.md
# UART Receive/Transmit Status Flag Controller

This block keeps the status word of a simple UART and produces its receive and transmit interrupt requests. The receive and transmit shifters report to it with single-cycle event strobes: start bit seen, stop bit seen, frame complete (with framing-error and parity-error qualifiers), word moved into the transmit shifter, and transmission finished. The bus side reads the received-data register, writes the transmit holding register, reads and writes the status word, and writes a receive-flag-clear control bit.

The block also holds both data registers. It decides whether a completed frame is accepted. A frame is refused while an error flag is pending. A frame that arrives while the previous one is still unread is reported as an overrun. Overrun and framing error share one flag. The two cases are told apart by the data-full flag: error with full means overrun, and error without full means framing error.

All flags and data registers are clocked. Each one shows the effect of a strobe on the clock edge that samples the strobe. The interrupt requests are level outputs, formed each cycle from the registered flags and enables.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset, the status word reads 16'h1000 (only transmit-empty at bit 12 is set), and both interrupt requests are low.
- R2: A frame-complete strobe with no error qualifier loads `rx_shift_data` into the received-data register and sets data-full (bit 15). This applies only when data-full, the error flag (bit 14) and the parity flag (bit 13) are all clear. Afterwards the pair {bit15, bit14} reads 2'b10.
- R3: A read strobe on the received-data register clears data-full on the next edge.
- R4: A clean frame that completes while data-full is still set raises the error flag and leaves the held data unchanged. The pair {bit15, bit14} then reads 2'b11.
- R5: A frame flagged with a framing error raises the error flag and discards its data. Data-full keeps its value, so from empty the pair reads 2'b01.
- R6: A frame flagged with a parity error raises the parity flag (bit 13) and is not loaded.
- R7: While the error flag or the parity flag is set, a clean frame is not loaded. Writing 0 to the receive-flag-clear bit clears data-full, the error flag and the parity flag. Writing 1 to it changes nothing.
- R8: `irq_rx` is high exactly while the receive enable (bit 11) is set and at least one of data-full, error or parity is set.
- R9: A write to the transmit holding register stores the word on `tx_hold_data`, clears transmit-empty and sets transmitter busy (bit 8). A transmit-load strobe sets transmit-empty again.
- R10: `irq_tx` is high while the transmit enable (bit 10) and transmit-empty are both set. Turning the enable on while empty is already set raises it at the next edge.
- R11: Receiver busy (bit 9) is set by a start-bit strobe and cleared by a stop-bit strobe. Transmitter busy is cleared by a transmit-done strobe.
- R12: A status write changes only the two enable bits, taken from `stat_wdata[11]` and `stat_wdata[10]`. Values written to the other bits have no effect, and bits 7..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start_det | input | 1 | Receive shifter saw a start bit |
| rx_stop_det | input | 1 | Receive shifter saw a stop bit |
| rx_frame_done | input | 1 | Receive frame complete |
| rx_frame_err | input | 1 | Qualifier: completed frame has a framing error |
| rx_parity_err | input | 1 | Qualifier: completed frame has a parity error |
| rx_shift_data | input | DW | Data of the completed frame |
| tx_load | input | 1 | Holding word moved into transmit shifter |
| tx_done | input | 1 | Transmission finished |
| idr_rd | input | 1 | Bus read of received-data register |
| idr_rdata | output | DW | Received-data register |
| odr_wr | input | 1 | Bus write of transmit holding register |
| odr_wdata | input | DW | Transmit write data |
| tx_hold_data | output | DW | Transmit holding register, to the shifter |
| stat_wr | input | 1 | Bus write of status word |
| stat_wdata | input | 16 | Status write data |
| stat_rdata | output | 16 | Status word |
| rfc_wr | input | 1 | Write of receive-flag-clear bit |
| rfc_wdata | input | 1 | Value written to receive-flag-clear bit |
| irq_rx | output | 1 | Receive interrupt request (level) |
| irq_tx | output | 1 | Transmit interrupt request (level) |

## Verification
Every flag, enable and data register changes on the clock edge that samples its strobe. The interrupt requests follow with no further delay, because they are combinational from those registers. The bench therefore drives each strobe for exactly one cycle, starting at a falling edge. It checks the status word, the data outputs and both requests at the next falling edge, which is one edge after the stimulus. Checks that a stimulus had no effect are read the same way, in that same cycle, before the next stimulus is applied.

// File: rtl/uart_flag_pkg.sv
// Package: bit positions of the status word, shared by the controller,
// the checker and anyone decoding the word. Assumes a 16-bit status word.
package uart_flag_pkg;
    localparam int STAT_W     = 16;
    localparam int B_RX_FULL  = 15;
    localparam int B_RX_ERR   = 14;
    localparam int B_RX_PAR   = 13;
    localparam int B_TX_EMPTY = 12;
    localparam int B_RX_IE    = 11;
    localparam int B_TX_IE    = 10;
    localparam int B_RX_BUSY  = 9;
    localparam int B_TX_BUSY  = 8;
endpackage

// File: rtl/uart_rx_flags.sv
// Receive-side flags and received-data register.
// Decides per completed frame whether to load, report overrun, or drop.
// Assumes single-cycle strobes; set events win over clears in the same cycle.
module uart_rx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          frame_done,
    input  logic          frame_err,
    input  logic          parity_err,
    input  logic [DW-1:0] shift_data,
    input  logic          rd,
    input  logic          clr,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          err,
    output logic          par,
    output logic          busy
);
    logic full_d, err_d, par_d, load;
    logic clean, blocked, room;

    // Next-state of the receive flags and load decision for this cycle.
    always_comb begin
        clean   = frame_done && !frame_err && !parity_err;
        blocked = (err || par) && !clr;
        room    = !full || rd || clr;
        full_d  = full && !rd && !clr;
        err_d   = err && !clr;
        par_d   = par && !clr;
        load    = 1'b0;
        if (frame_done && frame_err)  err_d = 1'b1;
        if (frame_done && parity_err) par_d = 1'b1;
        if (clean && !blocked) begin
            if (room) begin
                load   = 1'b1;
                full_d = 1'b1;
            end else begin
                err_d  = 1'b1;
            end
        end
    end

    // Register the flags and the received data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            err  <= 1'b0;
            par  <= 1'b0;
            data <= '0;
        end else begin
            full <= full_d;
            err  <= err_d;
            par  <= par_d;
            if (load) data <= shift_data;
        end
    end

    // Receiver busy: set by start bit, cleared by stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_det) busy <= 1'b1;
        else if (stop_det)  busy <= 1'b0;
    end
endmodule

// File: rtl/uart_tx_flags.sv
// Transmit holding register with empty and busy flags.
// Assumes a bus write and a shifter load in the same cycle leave the
// register full (the write is newer).
module uart_tx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    input  logic          done,
    output logic [DW-1:0] hold,
    output logic          empty,
    output logic          busy
);
    // Holding register and empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= '0;
            empty <= 1'b1;
        end else if (wr) begin
            hold  <= wdata;
            empty <= 1'b0;
        end else if (load) begin
            empty <= 1'b1;
        end
    end

    // Transmitter busy: set by a bus write, cleared by transmit done.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy <= 1'b0;
        else if (wr)   busy <= 1'b1;
        else if (done) busy <= 1'b0;
    end
endmodule

// File: rtl/uart_flag_ctrl.sv
// Top: UART status word, interrupt enables and level interrupt requests.
// Assumes strobes are one cycle wide and synchronous to clk.
module uart_flag_ctrl
    import uart_flag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start_det,
    input  logic              rx_stop_det,
    input  logic              rx_frame_done,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic [DW-1:0]     rx_shift_data,
    input  logic              tx_load,
    input  logic              tx_done,
    input  logic              idr_rd,
    output logic [DW-1:0]     idr_rdata,
    input  logic              odr_wr,
    input  logic [DW-1:0]     odr_wdata,
    output logic [DW-1:0]     tx_hold_data,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    input  logic              rfc_wr,
    input  logic              rfc_wdata,
    output logic              irq_rx,
    output logic              irq_tx
);
    logic rx_full, rx_err, rx_par, rx_busy;
    logic tx_empty, tx_busy;
    logic rx_ie, tx_ie;
    logic rx_clr;
    logic unused_wbits;

    assign rx_clr       = rfc_wr && !rfc_wdata;
    assign unused_wbits = ^{stat_wdata[STAT_W-1:B_RX_IE+1], stat_wdata[B_TX_IE-1:0]};

    uart_rx_flags #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .start_det(rx_start_det), .stop_det(rx_stop_det),
        .frame_done(rx_frame_done), .frame_err(rx_frame_err),
        .parity_err(rx_parity_err), .shift_data(rx_shift_data),
        .rd(idr_rd), .clr(rx_clr), .data(idr_rdata),
        .full(rx_full), .err(rx_err), .par(rx_par), .busy(rx_busy)
    );

    uart_tx_flags #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .wr(odr_wr), .wdata(odr_wdata), .load(tx_load), .done(tx_done),
        .hold(tx_hold_data), .empty(tx_empty), .busy(tx_busy)
    );

    // Interrupt enable bits, the only writable part of the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie <= 1'b0;
            tx_ie <= 1'b0;
        end else if (stat_wr) begin
            rx_ie <= stat_wdata[B_RX_IE];
            tx_ie <= stat_wdata[B_TX_IE];
        end
    end

    // Assemble the status word from the flag owners.
    always_comb begin
        stat_rdata             = '0;
        stat_rdata[B_RX_FULL]  = rx_full;
        stat_rdata[B_RX_ERR]   = rx_err;
        stat_rdata[B_RX_PAR]   = rx_par;
        stat_rdata[B_TX_EMPTY] = tx_empty;
        stat_rdata[B_RX_IE]    = rx_ie;
        stat_rdata[B_TX_IE]    = tx_ie;
        stat_rdata[B_RX_BUSY]  = rx_busy;
        stat_rdata[B_TX_BUSY]  = tx_busy;
    end

    // Level interrupt requests: flags gated by their enables.
    assign irq_rx = rx_ie && (rx_full || rx_err || rx_par);
    assign irq_tx = tx_ie && tx_empty;
endmodule

// File: rtl/uart_flag_chk.sv
// Checker for uart_flag_ctrl: port-level temporal properties, bound below.
module uart_flag_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_start_det,
    input logic          rx_stop_det,
    input logic          rx_frame_done,
    input logic          rx_frame_err,
    input logic          rx_parity_err,
    input logic [DW-1:0] rx_shift_data,
    input logic          tx_load,
    input logic          tx_done,
    input logic          idr_rd,
    input logic [DW-1:0] idr_rdata,
    input logic          odr_wr,
    input logic [DW-1:0] odr_wdata,
    input logic [DW-1:0] tx_hold_data,
    input logic          stat_wr,
    input logic [15:0]   stat_wdata,
    input logic [15:0]   stat_rdata,
    input logic          rfc_wr,
    input logic          rfc_wdata,
    input logic          irq_rx,
    input logic          irq_tx
);
    logic clean, quiet;
    assign clean = rx_frame_done && !rx_frame_err && !rx_parity_err;
    assign quiet = !rx_frame_done && !idr_rd && !rfc_wr && !odr_wr && !tx_load
                   && !tx_done && !rx_start_det && !rx_stop_det;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clean && stat_rdata[15:13] == 3'b000
        |=> stat_rdata[15] && idr_rdata == $past(rx_shift_data));

    p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idr_rd && !rx_frame_done |=> !stat_rdata[15]);

    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clean && stat_rdata[15:13] == 3'b100 && !idr_rd && !rfc_wr
        |=> stat_rdata[15:14] == 2'b11 && $stable(idr_rdata));

    p_frame_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_done && rx_frame_err |=> stat_rdata[14] && $stable(idr_rdata));

    p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_done && rx_parity_err |=> stat_rdata[13] && $stable(idr_rdata));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rfc_wr && !rfc_wdata && !rx_frame_done |=> stat_rdata[15:13] == 3'b000);

    p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[15]) && stat_rdata[11] |-> irq_rx);

    p_tx_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        odr_wr |=> !stat_rdata[12] && stat_rdata[8] && tx_hold_data == $past(odr_wdata));

    p_irq_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && stat_wdata[10] && stat_rdata[12] && !odr_wr |=> irq_tx);

    p_rbusy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_det |=> stat_rdata[9]);

    p_ro_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && quiet |=> $stable(stat_rdata[15:12]) && $stable(stat_rdata[9:0]));
endmodule

bind uart_flag_ctrl uart_flag_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_start_det(rx_start_det), .rx_stop_det(rx_stop_det),
    .rx_frame_done(rx_frame_done), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .rx_shift_data(rx_shift_data),
    .tx_load(tx_load), .tx_done(tx_done), .idr_rd(idr_rd), .idr_rdata(idr_rdata),
    .odr_wr(odr_wr), .odr_wdata(odr_wdata), .tx_hold_data(tx_hold_data),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .rfc_wr(rfc_wr), .rfc_wdata(rfc_wdata), .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/test_uart_flag_ctrl.sv
// Directed bench: one task per scenario, each checking its own results
// one falling edge after the clock edge that samples its stimulus.
module test_uart_flag_ctrl;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_start_det = 0, rx_stop_det = 0, rx_frame_done = 0;
    logic          rx_frame_err = 0, rx_parity_err = 0;
    logic [DW-1:0] rx_shift_data = '0;
    logic          tx_load = 0, tx_done = 0, idr_rd = 0, odr_wr = 0;
    logic [DW-1:0] odr_wdata = '0;
    logic          stat_wr = 0, rfc_wr = 0, rfc_wdata = 0;
    logic [15:0]   stat_wdata = '0;
    logic [DW-1:0] idr_rdata, tx_hold_data;
    logic [15:0]   stat_rdata;
    logic          irq_rx, irq_tx;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uart_flag_ctrl #(.DW(DW)) i_uart_flag_ctrl (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Finish one strobe cycle: let the edge sample it, release at the next fall.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        rx_start_det = 0; rx_stop_det = 0; rx_frame_done = 0;
        rx_frame_err = 0; rx_parity_err = 0; tx_load = 0; tx_done = 0;
        idr_rd = 0; odr_wr = 0; stat_wr = 0; rfc_wr = 0;
    endtask

    task automatic frame(input logic [7:0] d, input logic fe, input logic pe);
        rx_frame_done = 1; rx_shift_data = d; rx_frame_err = fe; rx_parity_err = pe;
        step();
    endtask
    task automatic wr_stat(input logic [15:0] v); stat_wr = 1; stat_wdata = v; step(); endtask
    task automatic rfc(input logic v);            rfc_wr = 1; rfc_wdata = v; step(); endtask

    task automatic t_reset();
        check("R1 status", stat_rdata, 32'h1000);
        check("R1 irqs", {irq_rx, irq_tx}, 0);
    endtask

    task automatic t_good_frame();
        frame(8'hA5, 0, 0);
        check("R2 pair", stat_rdata[15:14], 2'b10);
        check("R2 data", idr_rdata, 8'hA5);
        wr_stat(16'h0800);
        check("R8 irq_rx on full", irq_rx, 1);
        idr_rd = 1; step();
        check("R3 full cleared", stat_rdata[15], 0);
        check("R8 irq_rx drops", irq_rx, 0);
    endtask

    task automatic t_overrun();
        frame(8'h3C, 0, 0);
        frame(8'hC3, 0, 0);
        check("R4 pair", stat_rdata[15:14], 2'b11);
        check("R4 data kept", idr_rdata, 8'h3C);
        rfc(1'b1);
        check("R7 write 1 no effect", stat_rdata[15:13], 3'b110);
        rfc(1'b0);
        check("R7 clear", stat_rdata[15:13], 3'b000);
    endtask

    task automatic t_framing();
        frame(8'h77, 1, 0);
        check("R5 pair", stat_rdata[15:14], 2'b01);
        check("R5 data discarded", idr_rdata, 8'h3C);
        frame(8'h11, 0, 0);
        check("R7 blocked full", stat_rdata[15], 0);
        check("R7 blocked data", idr_rdata, 8'h3C);
        rfc(1'b0);
        check("R7 clear after framing", stat_rdata[15:13], 3'b000);
    endtask

    task automatic t_parity();
        frame(8'h99, 0, 1);
        check("R6 parity flag", stat_rdata[15:13], 3'b001);
        check("R6 no load", idr_rdata, 8'h3C);
        check("R8 irq_rx on parity", irq_rx, 1);
        frame(8'h22, 0, 0);
        check("R7 blocked by parity", idr_rdata, 8'h3C);
        rfc(1'b0);
        check("R7 clear parity", stat_rdata[13], 0);
        frame(8'h5E, 0, 0);
        check("R2 load after clear", idr_rdata, 8'h5E);
        idr_rd = 1; step();
    endtask

    task automatic t_tx();
        wr_stat(16'h0400);
        check("R10 irq_tx on enable", irq_tx, 1);
        odr_wr = 1; odr_wdata = 8'h5A; step();
        check("R9 empty/busy", {stat_rdata[12], stat_rdata[8]}, 2'b01);
        check("R9 hold", tx_hold_data, 8'h5A);
        check("R10 irq_tx low", irq_tx, 0);
        tx_load = 1; step();
        check("R9 empty after load", stat_rdata[12], 1);
        check("R10 irq_tx after load", irq_tx, 1);
        check("R11 tx busy held", stat_rdata[8], 1);
        tx_done = 1; step();
        check("R11 tx busy cleared", stat_rdata[8], 0);
    endtask

    task automatic t_rx_busy();
        rx_start_det = 1; step();
        check("R11 rx busy set", stat_rdata[9], 1);
        rx_stop_det = 1; step();
        check("R11 rx busy cleared", stat_rdata[9], 0);
    endtask

    task automatic t_readonly();
        wr_stat(16'hF3FF);
        check("R12 status after write", stat_rdata, 32'h1000);
        check("R12 irq_tx off", irq_tx, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_good_frame();
        t_overrun();
        t_framing();
        t_parity();
        t_tx();
        t_rx_busy();
        t_readonly();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule